// File: doc/BRIEF.md
# Exception and Privilege Control Coprocessor

This block is the system-control unit beside a small 32-bit RISC core. It keeps four architectural registers: the machine state word, the event-reason word, the resume address and the faulting address. Every cycle it looks at three sources of events. The first is the core's own exception request. The second is an address check on the current memory access. The third is the set of qualified interrupt lines. When any of them fires, it tells the fetch stage to jump to one fixed handler address. In the same clock it saves where execution should resume and pushes the privilege and interrupt-enable stack.

The core uses the block in three ways. It reports the program counter of its oldest instruction and whether that instruction sits in a branch delay slot. It raises a return command when the handler finishes; the core itself then jumps to the saved resume address. Software reads and writes the registers through a move-to port and a move-from port, each indexed by register number. Both ports work only while the core is in kernel mode.

Top module: `sysctl_cop`

## Requirements
- R1: When an event is taken, `trap_take` is high in the same cycle and `trap_vector` reads 0x80000080.
- R2: On a taken event the resume register (index 14) captures `cur_pc`. If `cur_bd` is high it captures `cur_pc` minus 4 instead and sets bit 31 of the reason word. For a syscall (code 8) the captured value is the address of the syscall instruction itself.
- R3: On a taken event the reason word (index 13) gets the event code in bits 6:2. Bits 29:28 get `exc_cop` when the code is 11, and 0 otherwise. Bits 15:10 follow `hw_irq` one cycle later on every clock.
- R4: The state word (index 12) keeps a stack of three (interrupt-enable, user-mode) pairs in bits 5:0. Bit 0 is the current enable and bit 1 is the current mode, where 1 means user. On a taken event bits 5:2 receive the old bits 3:0 and bits 1:0 become 0, which gives kernel mode with interrupts off.
- R5: A return command (`rfe`) without a simultaneous event copies bits 5:2 of the state word into bits 3:0 and leaves bits 5:4 unchanged.
- R6: An interrupt is taken with code 0 only when some reason-word bit in 15:8 and the same state-word bit in 15:8 are both 1, and state bit 0 is 1.
- R7: When several events arrive in one cycle, an address fault wins over a core exception request, and a core request wins over an interrupt.
- R8: In user mode, a valid access whose address has bit 31 set raises code 4 for a load or fetch and code 5 for a store. In kernel mode the same access raises nothing.
- R9: The faulting-address register (index 8) loads `acc_addr` on an address fault. It is unchanged by every other event, including bus errors (codes 6 and 7), and by software writes.
- R10: Reads of indices 8, 12, 13 and 14 return those registers, and all other indices read 0. In user mode every read returns 0 and every write is ignored.
- R11: A state-word write keeps only bits 31:25, 15:8 and 5:0; the other bits read 0. A reason-word write changes only bits 9:8.
- R12: A taken event in the same cycle as a write or a return command wins, and the write or return is dropped.
- R13: After reset all four registers read 0, so the core starts in kernel mode with interrupts off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | Address of the oldest instruction in the core |
| cur_bd | input | 1 | Oldest instruction is in a branch delay slot |
| exc_req | input | 1 | Core reports a synchronous exception |
| exc_code | input | 5 | Code of the core's exception |
| exc_cop | input | 2 | Coprocessor number for an unusable-coprocessor event |
| acc_valid | input | 1 | A load, store or fetch access is presented |
| acc_store | input | 1 | The access is a store |
| acc_addr | input | 32 | Virtual address of the access |
| hw_irq | input | 6 | External interrupt lines |
| rfe | input | 1 | Return-from-exception command |
| mt_en | input | 1 | Software register write strobe |
| mt_idx | input | 5 | Register number to write |
| mt_data | input | 32 | Write data |
| mf_idx | input | 5 | Register number to read |
| mf_data | output | 32 | Read data (combinational) |
| trap_take | output | 1 | An event is taken this cycle |
| trap_vector | output | 32 | Handler address for the fetch redirect |
| user_mode | output | 1 | Core currently runs in user mode |

## Verification
The clocked assertions check on every cycle that an event pushes the mode/enable stack, that a lone return command pops it, that the faulting-address register holds still unless an address fault is taken, and that user-mode writes leave the state and resume registers untouched. They also check that an address fault always wins arbitration and that an interrupt is never taken with the enable bit clear. Only the bench scenarios can show the register values seen through the read port. These include the delay-slot resume address, the coprocessor-number field, the write masks, the one-cycle lag of the external pending bits and the dropping of writes that collide with events. The bench compares all of them against a register-level reference model that it runs alongside random traffic.

// File: rtl/cop_pkg.sv
package cop_pkg;
    parameter int unsigned XLEN     = 32;
    parameter int unsigned CODE_W   = 5;
    parameter int unsigned IDX_W    = 5;
    parameter int unsigned N_HW_IRQ = 6;
    parameter int unsigned N_SW_IRQ = 2;
    parameter int unsigned CE_W     = 2;
    localparam int unsigned N_IRQ   = N_HW_IRQ + N_SW_IRQ;

    localparam int unsigned PAIR_W  = 2;
    localparam int unsigned STACK_W = 3 * PAIR_W;
    localparam int unsigned ST_IEC  = 0;
    localparam int unsigned ST_KUC  = 1;
    localparam int unsigned ST_IM_LO   = 8;
    localparam int unsigned CA_IP_LO   = 8;
    localparam int unsigned CA_CODE_LO = 2;
    localparam int unsigned CA_CE_LO   = 28;
    localparam int unsigned CA_BD      = 31;

    localparam logic [XLEN-1:0] STATUS_WMASK = 32'hFE00_FF3F;
    localparam logic [XLEN-1:0] PC_STEP      = 4;

    localparam logic [IDX_W-1:0] IDX_FADDR  = 5'd8;
    localparam logic [IDX_W-1:0] IDX_STATE  = 5'd12;
    localparam logic [IDX_W-1:0] IDX_REASON = 5'd13;
    localparam logic [IDX_W-1:0] IDX_RESUME = 5'd14;

    localparam logic [CODE_W-1:0] CODE_INT  = 5'd0;
    localparam logic [CODE_W-1:0] CODE_ADL  = 5'd4;
    localparam logic [CODE_W-1:0] CODE_ADS  = 5'd5;
    localparam logic [CODE_W-1:0] CODE_COPU = 5'd11;

    typedef struct packed {
        logic [XLEN-1:0] state;
        logic [XLEN-1:0] reason;
        logic [XLEN-1:0] resume;
        logic [XLEN-1:0] faddr;
    } cop_regs_t;
endpackage

// File: rtl/cop_addr_guard.sv
module cop_addr_guard
    import cop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_store,
    input  logic [XLEN-1:0]   acc_addr,
    input  logic              user_mode,
    output logic              fault,
    output logic [CODE_W-1:0] fault_code
);
    localparam int unsigned PRIV_BIT = XLEN - 1;

    always_comb begin
        fault      = acc_valid && user_mode && acc_addr[PRIV_BIT];
        fault_code = acc_store ? CODE_ADS : CODE_ADL;
    end

    // R8: kernel-mode accesses never fault
    assert_kernel_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !user_mode |-> !fault);
endmodule

// File: rtl/cop_event_arb.sv
module cop_event_arb
    import cop_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              guard_fault,
    input  logic [CODE_W-1:0] guard_code,
    input  logic              exc_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic [CE_W-1:0]   exc_cop,
    input  logic [N_IRQ-1:0]  ip,
    input  logic [N_IRQ-1:0]  im,
    input  logic              ie_cur,
    output logic              take,
    output logic [CODE_W-1:0] code,
    output logic [CE_W-1:0]   ce,
    output logic              from_guard,
    output logic              irq_take
);
    logic [N_IRQ-1:0] qual;

    for (genvar i = 0; i < N_IRQ; i++) begin : g_qual
        assign qual[i] = ip[i] & im[i];
    end

    always_comb begin
        from_guard = guard_fault;
        irq_take   = !guard_fault && !exc_req && ie_cur && (|qual);
        take       = guard_fault || exc_req || irq_take;
        if (guard_fault)  code = guard_code;
        else if (exc_req) code = exc_code;
        else              code = CODE_INT;
        ce = (!guard_fault && exc_req && exc_code == CODE_COPU) ? exc_cop : '0;
    end

    // R7: an address fault always wins and carries its own code
    assert_guard_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        guard_fault |-> (take && from_guard && code == guard_code));
    // R6: interrupts only with the global enable set, reported as code 0
    assert_irq_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> (ie_cur && take && code == CODE_INT));
endmodule

// File: rtl/cop_state.sv
module cop_state
    import cop_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                take,
    input  logic [CODE_W-1:0]   code,
    input  logic [CE_W-1:0]     ce,
    input  logic                from_guard,
    input  logic [XLEN-1:0]     acc_addr,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                cur_bd,
    input  logic [N_HW_IRQ-1:0] hw_irq,
    input  logic                rfe,
    input  logic                mt_en,
    input  logic [IDX_W-1:0]    mt_idx,
    input  logic [XLEN-1:0]     mt_data,
    output cop_regs_t           regs_q
);
    cop_regs_t regs_d;
    logic      user_q;

    assign user_q = regs_q.state[ST_KUC];

    always_comb begin
        regs_d = regs_q;
        regs_d.reason[CA_IP_LO+N_SW_IRQ +: N_HW_IRQ] = hw_irq;
        if (take) begin
            regs_d.state[STACK_W-1:0] = {regs_q.state[STACK_W-PAIR_W-1:0], {PAIR_W{1'b0}}};
            regs_d.resume             = cur_bd ? (cur_pc - PC_STEP) : cur_pc;
            regs_d.reason[CA_BD]      = cur_bd;
            regs_d.reason[CA_CE_LO +: CE_W]     = ce;
            regs_d.reason[CA_CODE_LO +: CODE_W] = code;
            if (from_guard) regs_d.faddr = acc_addr;
        end else if (rfe) begin
            regs_d.state[STACK_W-PAIR_W-1:0] = regs_q.state[STACK_W-1:PAIR_W];
        end else if (mt_en && !user_q) begin
            case (mt_idx)
                IDX_STATE:  regs_d.state = mt_data & STATUS_WMASK;
                IDX_REASON: regs_d.reason[CA_IP_LO +: N_SW_IRQ] = mt_data[CA_IP_LO +: N_SW_IRQ];
                IDX_RESUME: regs_d.resume = mt_data;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // R4: entry pushes the stack and lands in kernel mode with interrupts off
    assert_entry_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (regs_q.state[STACK_W-1:PAIR_W] == $past(regs_q.state[STACK_W-PAIR_W-1:0])
                  && regs_q.state[PAIR_W-1:0] == '0));
    // R5: a lone return pops the stack and keeps the oldest pair
    assert_rfe_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rfe && !take) |=> (regs_q.state[STACK_W-PAIR_W-1:0] == $past(regs_q.state[STACK_W-1:PAIR_W])
                            && $stable(regs_q.state[STACK_W-1:STACK_W-PAIR_W])));
    // R9: faulting address moves only on a taken address fault
    assert_faddr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(take && from_guard) |=> $stable(regs_q.faddr));
    // R10: user-mode writes leave state and resume registers alone
    assert_user_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mt_en && user_q && !take && !rfe) |=> ($stable(regs_q.state) && $stable(regs_q.resume)));
endmodule

// File: rtl/sysctl_cop.sv
module sysctl_cop
    import cop_pkg::*;
#(
    parameter logic [XLEN-1:0] HANDLER_VEC = 32'h8000_0080
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [XLEN-1:0]     cur_pc,
    input  logic                cur_bd,
    input  logic                exc_req,
    input  logic [CODE_W-1:0]   exc_code,
    input  logic [CE_W-1:0]     exc_cop,
    input  logic                acc_valid,
    input  logic                acc_store,
    input  logic [XLEN-1:0]     acc_addr,
    input  logic [N_HW_IRQ-1:0] hw_irq,
    input  logic                rfe,
    input  logic                mt_en,
    input  logic [IDX_W-1:0]    mt_idx,
    input  logic [XLEN-1:0]     mt_data,
    input  logic [IDX_W-1:0]    mf_idx,
    output logic [XLEN-1:0]     mf_data,
    output logic                trap_take,
    output logic [XLEN-1:0]     trap_vector,
    output logic                user_mode
);
    cop_regs_t         regs_q;
    logic              g_fault;
    logic [CODE_W-1:0] g_code;
    logic              a_take;
    logic [CODE_W-1:0] a_code;
    logic [CE_W-1:0]   a_ce;
    logic              a_from_guard;
    logic              a_irq;

    assign user_mode   = regs_q.state[ST_KUC];
    assign trap_take   = a_take;
    assign trap_vector = HANDLER_VEC;

    cop_addr_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_store  (acc_store),
        .acc_addr   (acc_addr),
        .user_mode  (user_mode),
        .fault      (g_fault),
        .fault_code (g_code)
    );

    cop_event_arb u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .guard_fault (g_fault),
        .guard_code  (g_code),
        .exc_req     (exc_req),
        .exc_code    (exc_code),
        .exc_cop     (exc_cop),
        .ip          (regs_q.reason[CA_IP_LO +: N_IRQ]),
        .im          (regs_q.state[ST_IM_LO +: N_IRQ]),
        .ie_cur      (regs_q.state[ST_IEC]),
        .take        (a_take),
        .code        (a_code),
        .ce          (a_ce),
        .from_guard  (a_from_guard),
        .irq_take    (a_irq)
    );

    cop_state u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (a_take),
        .code       (a_code),
        .ce         (a_ce),
        .from_guard (a_from_guard),
        .acc_addr   (acc_addr),
        .cur_pc     (cur_pc),
        .cur_bd     (cur_bd),
        .hw_irq     (hw_irq),
        .rfe        (rfe),
        .mt_en      (mt_en),
        .mt_idx     (mt_idx),
        .mt_data    (mt_data),
        .regs_q     (regs_q)
    );

    always_comb begin
        mf_data = '0;
        if (!user_mode) begin
            case (mf_idx)
                IDX_FADDR:  mf_data = regs_q.faddr;
                IDX_STATE:  mf_data = regs_q.state;
                IDX_REASON: mf_data = regs_q.reason;
                IDX_RESUME: mf_data = regs_q.resume;
                default:    mf_data = '0;
            endcase
        end
    end

    // R1: an event leaves the machine in kernel mode on the next cycle
    assert_entry_kernel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        trap_take |=> !user_mode);
endmodule

// File: tb/sysctl_cop_test.sv
module sysctl_cop_test;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cur_pc = '0;
    logic        cur_bd = 1'b0;
    logic        exc_req = 1'b0;
    logic [4:0]  exc_code = '0;
    logic [1:0]  exc_cop = '0;
    logic        acc_valid = 1'b0;
    logic        acc_store = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [5:0]  hw_irq = '0;
    logic        rfe = 1'b0;
    logic        mt_en = 1'b0;
    logic [4:0]  mt_idx = '0;
    logic [31:0] mt_data = '0;
    logic [4:0]  mf_idx = '0;
    logic [31:0] mf_data;
    logic        trap_take;
    logic [31:0] trap_vector;
    logic        user_mode;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 0;

    logic [31:0] m_state = '0, m_reason = '0, m_resume = '0, m_faddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sysctl_cop uut (
        .clk(clk), .rst_n(rst_n), .cur_pc(cur_pc), .cur_bd(cur_bd),
        .exc_req(exc_req), .exc_code(exc_code), .exc_cop(exc_cop),
        .acc_valid(acc_valid), .acc_store(acc_store), .acc_addr(acc_addr),
        .hw_irq(hw_irq), .rfe(rfe), .mt_en(mt_en), .mt_idx(mt_idx),
        .mt_data(mt_data), .mf_idx(mf_idx), .mf_data(mf_data),
        .trap_take(trap_take), .trap_vector(trap_vector), .user_mode(user_mode)
    );

    task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(logic [4:0] idx);
        if (m_state[1]) return 32'h0;
        case (idx)
            5'd8:  return m_faddr;
            5'd12: return m_state;
            5'd13: return m_reason;
            5'd14: return m_resume;
            default: return 32'h0;
        endcase
    endfunction

    task automatic idle();
        exc_req = 0; exc_code = 0; exc_cop = 0; cur_bd = 0;
        acc_valid = 0; acc_store = 0; acc_addr = 0;
        rfe = 0; mt_en = 0; mt_idx = 0; mt_data = 0;
    endtask

    // one clock: check combinational outputs against the model, then advance it
    task automatic step();
        logic user, aerr, irq, take;
        logic [4:0] code;
        logic [7:0] pend;
        user = m_state[1];
        aerr = acc_valid && user && acc_addr[31];
        pend = m_reason[15:8] & m_state[15:8];
        irq  = (pend != 0) && m_state[0];
        take = aerr || exc_req || irq;
        code = aerr ? (acc_store ? 5'd5 : 5'd4) : (exc_req ? exc_code : 5'd0);
        #1;
        chk({31'b0, trap_take}, {31'b0, take}, "R7 event decision");
        if (take) chk(trap_vector, 32'h8000_0080, "R1 handler vector");
        chk({31'b0, user_mode}, {31'b0, user}, "R4 current mode");
        chk(mf_data, model_read(mf_idx), "R10 read port");
        @(posedge clk);
        if (take) begin
            m_state[5:0] = {m_state[3:0], 2'b00};
            m_resume     = cur_bd ? cur_pc - 32'd4 : cur_pc;
            m_reason[31] = cur_bd;
            m_reason[29:28] = (!aerr && exc_req && exc_code == 5'd11) ? exc_cop : 2'b00;
            m_reason[6:2] = code;
            if (aerr) m_faddr = acc_addr;
        end else if (rfe) begin
            m_state[3:0] = m_state[5:2];
        end else if (mt_en && !user) begin
            case (mt_idx)
                5'd12: m_state = mt_data & 32'hFE00_FF3F;
                5'd13: m_reason[9:8] = mt_data[9:8];
                5'd14: m_resume = mt_data;
                default: ;
            endcase
        end
        m_reason[15:10] = hw_irq;
        @(negedge clk);
    endtask

    task automatic wr(logic [4:0] idx, logic [31:0] data);
        idle(); mt_en = 1; mt_idx = idx; mt_data = data;
        step();
        idle();
    endtask

    task automatic rd_chk(logic [4:0] idx, logic [31:0] exp, string tag);
        mf_idx = idx;
        #1;
        chk(mf_data, exp, tag);
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R13 reset state
        rd_chk(5'd8, 0, "R13 faddr reset");
        rd_chk(5'd12, 0, "R13 state reset");
        rd_chk(5'd13, 0, "R13 reason reset");
        rd_chk(5'd14, 0, "R13 resume reset");
        chk({31'b0, user_mode}, 0, "R13 kernel after reset");

        // R11 write masks
        wr(5'd12, 32'hFFFF_FFFC);
        rd_chk(5'd12, 32'hFE00_FF3C, "R11 state write mask");
        wr(5'd13, 32'hFFFF_FFFF);
        rd_chk(5'd13, 32'h0000_0300, "R11 reason write mask");
        wr(5'd13, 0);
        rd_chk(5'd7, 0, "R10 unused index");

        // R2/R3/R4 syscall entry
        wr(5'd12, 32'h0000_000C);
        exc_req = 1; exc_code = 5'd8; cur_pc = 32'h0040_0100;
        step(); idle();
        rd_chk(5'd14, 32'h0040_0100, "R2 syscall resume address");
        mf_idx = 5'd13; #1;
        chk(mf_data & 32'h7C, 32'h20, "R3 code field");
        rd_chk(5'd12, 32'h0000_0030, "R4 stack push");

        // R5 pops
        rfe = 1; step(); idle();
        rd_chk(5'd12, 32'h0000_003C, "R5 first pop");
        rfe = 1; step(); idle();
        chk({31'b0, user_mode}, 1, "R5 back to user");
        rd_chk(5'd12, 0, "R10 user read blocked");

        // R10 user write ignored
        wr(5'd12, 32'h0);
        chk({31'b0, user_mode}, 1, "R10 user write ignored");

        // R8/R9 store fault
        acc_valid = 1; acc_store = 1; acc_addr = 32'h9000_0010; cur_pc = 32'h0040_0200;
        step(); idle();
        rd_chk(5'd8, 32'h9000_0010, "R9 faddr capture");
        mf_idx = 5'd13; #1;
        chk((mf_data >> 2) & 32'h1F, 5, "R8 store fault code");
        rd_chk(5'd12, 32'h0000_003C, "R4 push from user");

        // R8 kernel access to upper half
        acc_valid = 1; acc_addr = 32'hC000_0000; #1;
        chk({31'b0, trap_take}, 0, "R8 kernel no fault");
        step(); idle();

        // R9 bus error leaves faddr
        exc_req = 1; exc_code = 5'd7; step(); idle();
        rd_chk(5'd8, 32'h9000_0010, "R9 bus error no capture");
        wr(5'd8, 32'h1111_1111);
        rd_chk(5'd8, 32'h9000_0010, "R9 write ignored");

        // R8 load fault
        wr(5'd12, 32'h0000_0002);
        acc_valid = 1; acc_addr = 32'h8000_0000; step(); idle();
        mf_idx = 5'd13; #1;
        chk((mf_data >> 2) & 32'h1F, 4, "R8 load fault code");
        rd_chk(5'd8, 32'h8000_0000, "R9 load faddr");

        // R2 delay slot
        exc_req = 1; exc_code = 5'd12; cur_bd = 1; cur_pc = 32'h0040_0304;
        step(); idle();
        rd_chk(5'd14, 32'h0040_0300, "R2 delay slot resume");
        mf_idx = 5'd13; #1;
        chk(mf_data[31], 1, "R2 delay flag");

        // R6 external interrupt, one-cycle pending lag
        wr(5'd12, 32'h0000_0401);
        hw_irq = 6'b000001; #1;
        chk({31'b0, trap_take}, 0, "R3 pending lag");
        step();
        step();
        rd_chk(5'd12, 32'h0000_0404, "R6 interrupt entry");
        mf_idx = 5'd13; #1;
        chk(mf_data & 32'h0000_FC7C, 32'h0000_0400, "R6 code 0 with pending");
        wr(5'd12, 32'h0000_0001);
        #1; chk({31'b0, trap_take}, 0, "R6 masked line");
        hw_irq = 0; step();

        // R6 software interrupt
        wr(5'd13, 32'h0000_0100);
        wr(5'd12, 32'h0000_0101);
        #1; chk({31'b0, trap_take}, 1, "R6 software interrupt");
        step();

        // R7 priority: fault over request over interrupt
        wr(5'd12, 32'h0000_FF03);
        acc_valid = 1; acc_addr = 32'hA000_0000; exc_req = 1; exc_code = 5'd9;
        step(); idle();
        mf_idx = 5'd13; #1;
        chk((mf_data >> 2) & 32'h1F, 4, "R7 fault wins");
        wr(5'd12, 32'h0000_FF01);
        exc_req = 1; exc_code = 5'd9; step(); idle();
        mf_idx = 5'd13; #1;
        chk((mf_data >> 2) & 32'h1F, 9, "R7 request beats interrupt");
        wr(5'd13, 0);

        // R12 collisions
        mt_en = 1; mt_idx = 5'd14; mt_data = 32'hDEAD_0000;
        exc_req = 1; exc_code = 5'd13; cur_pc = 32'h0040_0500;
        step(); idle();
        rd_chk(5'd14, 32'h0040_0500, "R12 write dropped");
        wr(5'd12, 32'h0000_0010);
        rfe = 1; exc_req = 1; exc_code = 5'd10; step(); idle();
        rd_chk(5'd12, 32'h0000_0000, "R12 return dropped");

        // R3 coprocessor number
        exc_req = 1; exc_code = 5'd11; exc_cop = 2'd2; step(); idle();
        mf_idx = 5'd13; #1;
        chk(mf_data[29:28], 2, "R3 coprocessor field");

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] pick [5];
            pick[0] = 5'd8; pick[1] = 5'd12; pick[2] = 5'd13; pick[3] = 5'd14;
            pick[4] = 5'($urandom_range(0, 31));
            idle();
            cur_pc    = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
            cur_bd    = ($urandom_range(0, 7) == 0);
            exc_req   = ($urandom_range(0, 9) == 0);
            exc_code  = 5'($urandom_range(1, 15));
            exc_cop   = 2'($urandom_range(0, 3));
            acc_valid = ($urandom_range(0, 3) == 0);
            acc_store = 1'($urandom_range(0, 1));
            acc_addr  = $urandom;
            rfe       = ($urandom_range(0, 11) == 0);
            mt_en     = ($urandom_range(0, 3) == 0);
            mt_idx    = pick[$urandom_range(0, 4)];
            mt_data   = $urandom;
            mf_idx    = pick[$urandom_range(0, 4)];
            if ($urandom_range(0, 15) == 0) hw_irq = 6'($urandom);
            step();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule